// File: doc/BRIEF.md
# Status LED Pattern Blinker

This block turns the condition of a board's power sequencer and the configuration state of its FPGA into a single LED signal. The LED output can blink fast and without a break, show a repeating frame of eight equal time slots in which a count of leading slots is lit, or stay lit all the time. An operator can read the condition from the lamp alone: count the lit slots in each frame, or look for the fast blink or the steady light.

A prescaler divides the system clock into half-slot ticks. Every second half tick marks a slot boundary, about 178 ms apart by default. A frame of eight slots therefore repeats at roughly 0.7 Hz. The fast blink toggles the LED on every half tick, which gives about 5.6 Hz. The status inputs are read only at slot boundaries. When the status read there differs from the one on show, the frame starts again from its first slot.

Top module: `status_led_blinker`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `ledOut` is 0. The frame position is slot 0 and the status on show is the idle error.
- R2: A half tick occurs once every HALF = CLK_HZ*10/(SLOT_RATE_X10*2) cycles, counted from reset release. Every second half tick is a slot boundary. `ledOut` changes only in the cycle that follows a half tick.
- R3: Status is decoded from `pwrState` as follows: 2'b00 is the idle error, 2'b01 is the stage-one error and 2'b10 is the stage-two error. 2'b11 means power is ready; in that case `fpgaDone` = 1 means configured and 0 means not configured. Inputs are sampled only at slot boundaries, so a change between two boundaries has no effect on `ledOut`.
- R4: In the stage-one error, slots 0 to 4 of each frame are lit and slots 5 to 7 are dark.
- R5: In the stage-two error, slots 0 to 3 are lit and slots 4 to 7 are dark.
- R6: When power is ready and the FPGA is not configured, slots 0 to 2 are lit and slots 3 to 7 are dark.
- R7: When power is ready and the FPGA is configured, `ledOut` is held at 1.
- R8: In the idle error, `ledOut` inverts on every half tick. When the idle error is entered at a slot boundary from another status, `ledOut` turns on at that boundary.
- R9: At a slot boundary where the sampled status differs from the status on show, the frame restarts at slot 0 and that slot is shown at once. Otherwise the slot advances by one and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| pwrState | input | 2 | Power sequencer condition code |
| fpgaDone | input | 1 | FPGA configuration complete flag |
| ledOut | output | 1 | LED drive, 1 = lit |

## Verification
The bench builds the block with CLK_HZ = 1120 and SLOT_RATE_X10 = 56. This gives a half tick of 100 cycles, a slot of 200 cycles and a frame of 1600 cycles. At these values a single run covers many complete frames of every pattern, frame wraps, and status changes that fall both on and between slot boundaries. The bench also measures the exact spacing of the idle toggles and the period of the frame.

// File: rtl/status_blink_pkg.sv
package status_blink_pkg;

  localparam int FRAME_SLOTS = 8;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);

  typedef enum logic [2:0] {
    MODE_IDLE_ERR = 3'd0,
    MODE_SEQ1_ERR = 3'd1,
    MODE_SEQ2_ERR = 3'd2,
    MODE_UNCONFIG = 3'd3,
    MODE_SPARE2   = 3'd4,
    MODE_SPARE1   = 3'd5,
    MODE_STEADY   = 3'd6
  } blink_mode_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic restartFrame;
    logic advanceSlot;
    logic ledSet;
    logic ledClear;
    logic ledToggle;
  } blink_strobe_t;

  // Number of leading lit slots in a frame for each counting mode.
  function automatic logic [SLOT_W:0] litSlots(blink_mode_e m);
    case (m)
      MODE_SEQ1_ERR: return (SLOT_W+1)'(5);
      MODE_SEQ2_ERR: return (SLOT_W+1)'(4);
      MODE_UNCONFIG: return (SLOT_W+1)'(3);
      MODE_SPARE2:   return (SLOT_W+1)'(2);
      MODE_SPARE1:   return (SLOT_W+1)'(1);
      MODE_STEADY:   return (SLOT_W+1)'(FRAME_SLOTS);
      default:       return '0;
    endcase
  endfunction

  function automatic blink_mode_e decodeStatus(logic [1:0] pwr, logic done);
    case (pwr)
      2'b00:   return MODE_IDLE_ERR;
      2'b01:   return MODE_SEQ1_ERR;
      2'b10:   return MODE_SEQ2_ERR;
      default: return done ? MODE_STEADY : MODE_UNCONFIG;
    endcase
  endfunction

endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int HALF_CYCLES = 100
) (
  input  logic clk,
  input  logic rstN,
  output logic halfTick,
  output logic slotTick
);
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] preCnt;
  logic             slotPhase;
  logic             wrap;

  assign wrap = (preCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      slotPhase <= 1'b0;
    end else if (wrap) begin
      preCnt    <= '0;
      slotPhase <= ~slotPhase;
    end else begin
      preCnt <= preCnt + CNT_W'(1);
    end
  end

  assign halfTick = wrap;
  assign slotTick = wrap & slotPhase;
endmodule

// File: rtl/blink_datapath.sv
module blink_datapath
  import status_blink_pkg::*;
#(
  parameter int HALF_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  blink_strobe_t     strobe,
  output logic              halfTick,
  output logic              slotTick,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              ledQ
);
  blink_prescaler #(.HALF_CYCLES(HALF_CYCLES)) uPrescaler (
    .clk      (clk),
    .rstN     (rstN),
    .halfTick (halfTick),
    .slotTick (slotTick)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                   slotIdx <= '0;
    else if (strobe.restartFrame) slotIdx <= '0;
    else if (strobe.advanceSlot)  slotIdx <= slotIdx + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 ledQ <= 1'b0;
    else if (strobe.ledClear)  ledQ <= 1'b0;
    else if (strobe.ledSet)    ledQ <= 1'b1;
    else if (strobe.ledToggle) ledQ <= ~ledQ;
  end
endmodule

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import status_blink_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrState,
  input  logic              fpgaDone,
  input  logic              halfTick,
  input  logic              slotTick,
  input  logic [SLOT_W-1:0] slotIdx,
  output blink_strobe_t     strobe,
  output blink_mode_e       activeMode,
  output blink_mode_e       reqMode
);
  logic              changed;
  logic [SLOT_W-1:0] nextSlot;

  assign reqMode  = decodeStatus(pwrState, fpgaDone);
  assign changed  = (reqMode != activeMode);
  assign nextSlot = changed ? '0 : slotIdx + SLOT_W'(1);

  always_comb begin
    strobe = '0;
    if (slotTick) begin
      strobe.restartFrame = changed;
      strobe.advanceSlot  = ~changed;
      case (reqMode)
        MODE_IDLE_ERR: begin
          if (changed) strobe.ledSet    = 1'b1;
          else         strobe.ledToggle = 1'b1;
        end
        MODE_STEADY: strobe.ledSet = 1'b1;
        default: begin
          if ({1'b0, nextSlot} < litSlots(reqMode)) strobe.ledSet   = 1'b1;
          else                                       strobe.ledClear = 1'b1;
        end
      endcase
    end else if (halfTick && activeMode == MODE_IDLE_ERR) begin
      strobe.ledToggle = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        activeMode <= MODE_IDLE_ERR;
    else if (slotTick) activeMode <= reqMode;
  end
endmodule

// File: rtl/status_led_blinker.sv
module status_led_blinker
  import status_blink_pkg::*;
#(
  parameter int CLK_HZ        = 25_000_000,
  parameter int SLOT_RATE_X10 = 56
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwrState,
  input  logic       fpgaDone,
  output logic       ledOut
);
  localparam int HALF_CYCLES = (CLK_HZ * 10) / (SLOT_RATE_X10 * 2);

  blink_strobe_t     strobe;
  logic              halfTick;
  logic              slotTick;
  logic [SLOT_W-1:0] slotIdx;
  blink_mode_e       activeMode;
  blink_mode_e       reqMode;

  blink_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrState   (pwrState),
    .fpgaDone   (fpgaDone),
    .halfTick   (halfTick),
    .slotTick   (slotTick),
    .slotIdx    (slotIdx),
    .strobe     (strobe),
    .activeMode (activeMode),
    .reqMode    (reqMode)
  );

  blink_datapath #(.HALF_CYCLES(HALF_CYCLES)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .halfTick (halfTick),
    .slotTick (slotTick),
    .slotIdx  (slotIdx),
    .ledQ     (ledOut)
  );
endmodule

// File: rtl/status_led_blinker_chk.sv
module status_led_blinker_chk
  import status_blink_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ledOut,
  input logic              halfTick,
  input logic              slotTick,
  input logic [SLOT_W-1:0] slotIdx,
  input blink_mode_e       activeMode,
  input blink_mode_e       reqMode
);
  assert_led_on_half_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !halfTick |=> $stable(ledOut));

  assert_sample_at_boundary_R3: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(activeMode));

  assert_seq1_pattern_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && reqMode == MODE_SEQ1_ERR) |=> (ledOut == (slotIdx < 3'd5)));

  assert_seq2_pattern_R5: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && reqMode == MODE_SEQ2_ERR) |=> (ledOut == (slotIdx < 3'd4)));

  assert_unconfig_pattern_R6: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && reqMode == MODE_UNCONFIG) |=> (ledOut == (slotIdx < 3'd3)));

  assert_steady_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && reqMode == MODE_STEADY) |=> ledOut);

  assert_idle_toggle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (halfTick && activeMode == MODE_IDLE_ERR && reqMode == MODE_IDLE_ERR)
      |=> (ledOut != $past(ledOut)));

  assert_restart_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && reqMode != activeMode) |=> (slotIdx == '0));

  assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(slotIdx));
endmodule

bind status_led_blinker status_led_blinker_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .ledOut     (ledOut),
  .halfTick   (halfTick),
  .slotTick   (slotTick),
  .slotIdx    (slotIdx),
  .activeMode (activeMode),
  .reqMode    (reqMode)
);

// File: tb/status_led_blinker_test.sv
module status_led_blinker_test;
  localparam int CLK_PERIOD    = 10;
  localparam int CLK_HZ        = 1120;
  localparam int SLOT_RATE_X10 = 56;
  localparam int HALF          = (CLK_HZ * 10) / (SLOT_RATE_X10 * 2);
  localparam int WATCHDOG      = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwrState = 2'b00;
  logic       fpgaDone = 1'b0;
  logic       ledOut;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  bit finished = 0;

  status_led_blinker #(.CLK_HZ(CLK_HZ), .SLOT_RATE_X10(SLOT_RATE_X10)) uut (
    .clk(clk), .rstN(rstN), .pwrState(pwrState), .fpgaDone(fpgaDone), .ledOut(ledOut)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // Mode codes of the bench: 0 idle, 1 stage one, 2 stage two, 3 unconfigured, 6 steady
  function automatic int expMode(logic [1:0] p, logic d);
    case (p)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return 2;
      default: return d ? 6 : 3;
    endcase
  endfunction

  function automatic int expLit(int m);
    case (m)
      1: return 5;
      2: return 4;
      3: return 3;
      default: return 0;
    endcase
  endfunction

  // Reference state kept from the requirements
  int mPre, mSlot, mActive;
  bit mPhase, mLed, mRestart;

  always @(posedge clk) begin
    int req, ns;
    cycle <= cycle + 1;
    if (!rstN) begin
      mPre <= 0; mPhase <= 0; mSlot <= 0; mActive <= 0; mLed <= 0; mRestart <= 0;
    end else if (mPre == HALF - 1) begin
      mPre   <= 0;
      mPhase <= !mPhase;
      if (mPhase) begin
        req = expMode(pwrState, fpgaDone);
        ns  = (req != mActive) ? 0 : (mSlot + 1) % 8;
        mRestart <= (req != mActive);
        mSlot    <= ns;
        mActive  <= req;
        if (req == 0)      mLed <= (req != mActive) ? 1'b1 : !mLed;
        else if (req == 6) mLed <= 1'b1;
        else               mLed <= (ns < expLit(req));
      end else if (mActive == 0) begin
        mLed <= !mLed;
      end
    end else begin
      mPre <= mPre + 1;
    end
  end

  task automatic report(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, expv, cycle);
    end
  endtask

  task automatic checkNow();
    string tag;
    if (!rstN) tag = "R1";
    else if (expMode(pwrState, fpgaDone) != mActive) tag = "R3";
    else if (mRestart && mSlot == 0) tag = "R9";
    else case (mActive)
      0: tag = "R8";
      1: tag = "R4";
      2: tag = "R5";
      3: tag = "R6";
      default: tag = "R7";
    endcase
    report(tag, int'(ledOut), int'(mLed));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow();
    end
  endtask

  task automatic setStatus(logic [1:0] p, logic d);
    pwrState = p;
    fpgaDone = d;
  endtask

  // Cycles from one change of ledOut (in the given direction, or any) to the next
  task automatic gapOfChange(bit risingOnly, output int gap);
    logic prev;
    int   seen;
    seen = 0;
    gap  = 0;
    prev = ledOut;
    while (seen < 2) begin
      @(negedge clk);
      checkNow();
      if (seen == 1) gap++;
      if (ledOut != prev && (!risingOnly || ledOut)) seen++;
      prev = ledOut;
    end
  endtask

  initial begin
    int gap;
    void'($urandom(32'd4821));
    // R1: reset state
    run(5);
    rstN = 1'b1;
    run(1);

    // R8 and R2: idle toggles every half tick
    setStatus(2'b00, 1'b0);
    run(3200);
    gapOfChange(1'b0, gap);
    report("R2", gap, HALF);

    // R4, R5, R6, R7 directed frames
    setStatus(2'b01, 1'b0); run(4900);
    setStatus(2'b10, 1'b1); run(4900);
    setStatus(2'b11, 1'b0); run(3300);
    gapOfChange(1'b1, gap);
    report("R2", gap, 16 * HALF);
    setStatus(2'b11, 1'b1); run(3300);

    // R3: short pulse of another status between two slot boundaries
    setStatus(2'b01, 1'b0); run(1650);
    setStatus(2'b11, 1'b1); run(40);
    setStatus(2'b01, 1'b0); run(1600);

    // R9: back into idle from a counting mode, then into a counting mode mid-frame
    setStatus(2'b00, 1'b0); run(900);
    setStatus(2'b10, 1'b0); run(2300);

    // Random status segments
    for (int s = 0; s < 60; s++) begin
      setStatus(2'($urandom % 4), 1'($urandom % 2));
      run(20 + int'($urandom % 2500));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule